// File: doc/BRIEF.md
# Parallel NOR Flash Identification Sequencer

This block works out what kind of parallel NOR flash sits on an asynchronous memory-style bus when the chip starts up. After a single-cycle start request it issues the auto-select command writes and then reads back the manufacturer word and the device word. It sorts the bank into one of two command-set families: one that needs unlock cycles and one that uses a status register. It then writes the read-mode command that fits the family it found. The probe sequence is the same for both families, because a status-register device ignores the two unlock writes that come before the auto-select command.

From the device word the block looks up the bank geometry and reports it: the sector count, the total size in bytes and whether the part has its small boot sectors at the bottom. On a 32-bit bus two 16-bit devices sit side by side. In that case every command byte goes out on both 16-bit lanes, and the size it reports is doubled. A single-cycle done pulse marks the cycle in which all results are valid. The results then stay unchanged until the next probe finishes.

The manufacturer codes and the device codes the block compares against are parameters. The strobe width is a parameter too.

Top module: `nor_id_probe`

## Requirements
- R1: The probe begins with three bus writes in this order: byte 0xAA to word offset 0x555, byte 0x55 to word offset 0x2AA, and byte 0x90 to word offset 0x555. On the write data bus each command byte sits in bits [7:0] of every 16-bit lane, and bits [15:8] of each lane are zero.
- R2: Every bus cycle drives its address, and its data for writes, one clock before the strobe rises. The strobe stays high for exactly STROBE_CYC clocks. Address and data stay unchanged for one clock after the strobe falls. bus_wr_o and bus_rd_o are never high together, and between two bus cycles at least one clock passes with both strobes low.
- R3: After the three writes the block reads word offset 0 and then word offset 1. Each read strobe lasts STROBE_CYC clocks, and bus_rdata_i is sampled in the last clock of the strobe.
- R4: The family is decided from bits [7:0] of the word read at offset 0 only. MFG_UNLOCK gives family_o = 1 (unlock family), MFG_STATUS gives family_o = 2 (status family), and any other value gives family_o = 0. The higher bits of that word have no effect.
- R5: The device word read at offset 1 matches a code only when every one of its 16-bit lanes equals that code. With no match, or with family 0, the results are known_o = 0, sect_cnt_o = 0, size_o = 0 and bottom_boot_o = 0.
- R6: For a known bank the geometry is as follows. DEV_UNI64 gives 128 sectors, 8 MiB per 16-bit lane and bottom_boot_o = 0. DEV_BOT8 gives 23 sectors and 1 MiB, DEV_BOT16 gives 39 sectors and 2 MiB, DEV_BOT32 gives 71 sectors and 4 MiB, and DEV_BOT64 gives 135 sectors and 8 MiB; all four of these give bottom_boot_o = 1.
- R7: With BUS_W = 32, size_o is twice the size that the same device reports with BUS_W = 16.
- R8: When family_o is not 0, one more write follows the two reads. It goes to word offset 0 and carries byte 0xFF for family 2 or byte 0xF0 for family 1, laid out in the lanes as in R1. With family 0 this write is left out.
- R9: From the clock after an accepted start, busy_o is high until done_o. done_o is high for exactly one clock, and in that clock busy_o is low and the results are valid. The results then hold until the next done_o. Out of reset, busy_o, done_o, both strobes and all results are 0.
- R10: A start_i pulse while busy_o is high is ignored: the probe in progress finishes with a single done_o and its bus sequence does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to probe the bank |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle pulse; results valid |
| known_o | output | 1 | Manufacturer and device both recognised |
| family_o | output | 2 | 0 unknown, 1 unlock family, 2 status family |
| sect_cnt_o | output | 8 | Number of sectors in the bank |
| size_o | output | SIZE_W | Bank size in bytes |
| bottom_boot_o | output | 1 | Boot sectors at the low end |
| bus_addr_o | output | ADDR_W | Word offset on the flash bus |
| bus_wdata_o | output | BUS_W | Write data to the flash |
| bus_rdata_i | input | BUS_W | Read data from the flash |
| bus_wr_o | output | 1 | Write strobe, active high |
| bus_rd_o | output | 1 | Read strobe, active high |

## Verification
Two things can fall into the same cycle: a fresh start request and a bus cycle that is already under way. A second start can arrive while a strobe is high, or in the gap between the probe's reads and its restore write. The bench provokes this by pulsing start_i during a run. A model of the bus sequence, updated cycle by cycle, shows that the strobes, the address and the data follow the original run without a hiccup. The bench also counts the done pulses for that run. The restore decision coincides with the capture of the device word as well. So the cases cover a known manufacturer with a device that is unknown or matches on only one lane, where the restore write is still expected, and an unknown manufacturer, where it is not.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

  typedef enum logic [1:0] {
    FAM_NONE   = 2'd0,
    FAM_UNLOCK = 2'd1,
    FAM_STATUS = 2'd2
  } fam_e;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_SETUP,
    BUS_STRB,
    BUS_HOLD
  } bus_st_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ISSUE,
    SEQ_WAIT,
    SEQ_FIN
  } seq_st_e;

  typedef struct packed {
    logic [7:0] sects;
    logic [4:0] size_lg;   // log2 of bytes per 16-bit lane
    logic       bottom;
  } geo_t;

  localparam int unsigned GEO_N = 5;

  localparam logic [10:0] OFS_CYC1 = 11'h555;
  localparam logic [10:0] OFS_CYC2 = 11'h2AA;
  localparam logic [10:0] OFS_MFG  = 11'h000;
  localparam logic [10:0] OFS_DEV  = 11'h001;

  localparam logic [7:0] CMD_UNLK_A   = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B   = 8'h55;
  localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
  localparam logic [7:0] CMD_RDM_STAT = 8'hFF;
  localparam logic [7:0] CMD_RDM_UNLK = 8'hF0;

  localparam logic [2:0] STEP_MFG     = 3'd3;
  localparam logic [2:0] STEP_DEV     = 3'd4;
  localparam logic [2:0] STEP_RESTORE = 3'd5;

  // table order: uniform 64M, bottom 8M, 16M, 32M, 64M
  function automatic geo_t geo_of(input int unsigned idx);
    geo_t g;
    case (idx)
      0:       g = '{sects: 8'd128, size_lg: 5'd23, bottom: 1'b0};
      1:       g = '{sects: 8'd23,  size_lg: 5'd20, bottom: 1'b1};
      2:       g = '{sects: 8'd39,  size_lg: 5'd21, bottom: 1'b1};
      3:       g = '{sects: 8'd71,  size_lg: 5'd22, bottom: 1'b1};
      4:       g = '{sects: 8'd135, size_lg: 5'd23, bottom: 1'b1};
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_probe_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int BUS_W      = 32,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic              ack_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BUS_W-1:0]  bus_wdata_o,
  input  logic [BUS_W-1:0]  bus_rdata_i,
  output logic              bus_wr_o,
  output logic              bus_rd_o
);

  localparam int CNT_W = $clog2(STROBE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q;
  logic [BUS_W-1:0]  rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        BUS_IDLE: begin
          if (req_i) begin
            we_q   <= we_i;
            addr_q <= addr_i;
            data_q <= data_i;
            st_q   <= BUS_SETUP;
          end
        end
        BUS_SETUP: begin
          cnt_q <= '0;
          st_q  <= BUS_STRB;
        end
        BUS_STRB: begin
          if (cnt_q == CNT_LAST) begin
            if (!we_q) rdata_q <= bus_rdata_i;
            st_q <= BUS_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        BUS_HOLD: st_q <= BUS_IDLE;
        default:  st_q <= BUS_IDLE;
      endcase
    end
  end

  assign ack_o       = (st_q == BUS_HOLD);
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = data_q;
  assign bus_wr_o    = (st_q == BUS_STRB) &&  we_q;
  assign bus_rd_o    = (st_q == BUS_STRB) && !we_q;

endmodule

// File: rtl/nor_id_decode.sv
module nor_id_decode
  import nor_probe_pkg::*;
#(
  parameter int          BUS_W      = 32,
  parameter logic [7:0]  MFG_UNLOCK = 8'h01,
  parameter logic [7:0]  MFG_STATUS = 8'h89,
  parameter logic [15:0] DEV_UNI64  = 16'h22D7,
  parameter logic [15:0] DEV_BOT8   = 16'h88C1,
  parameter logic [15:0] DEV_BOT16  = 16'h88C3,
  parameter logic [15:0] DEV_BOT32  = 16'h88C5,
  parameter logic [15:0] DEV_BOT64  = 16'h88CD
) (
  input  logic [7:0]       mfg_i,
  input  logic [BUS_W-1:0] dev_i,
  output fam_e             fam_o,
  output logic             known_o,
  output geo_t             geo_o
);

  localparam int LANES = BUS_W / 16;
  localparam logic [GEO_N*16-1:0] CODES = {DEV_BOT64, DEV_BOT32, DEV_BOT16, DEV_BOT8, DEV_UNI64};

  logic [GEO_N-1:0] hit;

  for (genvar e = 0; e < GEO_N; e++) begin : g_match
    assign hit[e] = (dev_i == {LANES{CODES[e*16 +: 16]}});
  end

  always_comb begin
    if (mfg_i == MFG_UNLOCK)      fam_o = FAM_UNLOCK;
    else if (mfg_i == MFG_STATUS) fam_o = FAM_STATUS;
    else                          fam_o = FAM_NONE;
  end

  always_comb begin
    known_o = (fam_o != FAM_NONE) && (|hit);
    geo_o   = '0;
    if (known_o) begin
      for (int e = GEO_N - 1; e >= 0; e--) begin
        if (hit[e]) geo_o = geo_of(e);
      end
    end
  end

endmodule

// File: rtl/nor_probe_seq.sv
module nor_probe_seq
  import nor_probe_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BUS_W  = 32,
  parameter int SIZE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BUS_W-1:0]  data_o,
  input  logic              ack_i,
  input  logic [BUS_W-1:0]  rdata_i,
  output logic [7:0]        mfg_o,
  output logic [BUS_W-1:0]  dev_o,
  input  fam_e              fam_i,
  input  logic              known_i,
  input  geo_t              geo_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              known_o,
  output logic [1:0]        family_o,
  output logic [7:0]        sect_cnt_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              bottom_boot_o
);

  localparam int LANES   = BUS_W / 16;
  localparam int LANE_SH = $clog2(LANES);

  seq_st_e           st_q;
  logic [2:0]        step_q;
  logic [7:0]        mfg_q;
  logic [BUS_W-1:0]  dev_q;
  logic              done_q;
  logic              known_q;
  logic [1:0]        family_q;
  logic [7:0]        sect_q;
  logic [SIZE_W-1:0] size_q;
  logic              bottom_q;

  logic [10:0] cmd_ofs;
  logic [7:0]  cmd_byte;

  always_comb begin
    case (step_q)
      3'd0:     begin we_o = 1'b1; cmd_ofs = OFS_CYC1; cmd_byte = CMD_UNLK_A;  end
      3'd1:     begin we_o = 1'b1; cmd_ofs = OFS_CYC2; cmd_byte = CMD_UNLK_B;  end
      3'd2:     begin we_o = 1'b1; cmd_ofs = OFS_CYC1; cmd_byte = CMD_AUTOSEL; end
      STEP_MFG: begin we_o = 1'b0; cmd_ofs = OFS_MFG;  cmd_byte = 8'h00;       end
      STEP_DEV: begin we_o = 1'b0; cmd_ofs = OFS_DEV;  cmd_byte = 8'h00;       end
      default: begin
        we_o     = 1'b1;
        cmd_ofs  = OFS_MFG;
        cmd_byte = (fam_i == FAM_STATUS) ? CMD_RDM_STAT : CMD_RDM_UNLK;
      end
    endcase
  end

  assign addr_o = ADDR_W'(cmd_ofs);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_o[l*16 +: 16] = {8'h00, cmd_byte};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SEQ_IDLE;
      step_q   <= '0;
      mfg_q    <= '0;
      dev_q    <= '0;
      done_q   <= 1'b0;
      known_q  <= 1'b0;
      family_q <= '0;
      sect_q   <= '0;
      size_q   <= '0;
      bottom_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (start_i) begin
            step_q <= '0;
            st_q   <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: st_q <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (ack_i) begin
            if (step_q == STEP_MFG) mfg_q <= rdata_i[7:0];
            if (step_q == STEP_DEV) dev_q <= rdata_i;
            if (step_q == STEP_RESTORE) begin
              st_q <= SEQ_FIN;
            end else if (step_q == STEP_DEV && fam_i == FAM_NONE) begin
              st_q <= SEQ_FIN;
            end else begin
              step_q <= step_q + 3'd1;
              st_q   <= SEQ_ISSUE;
            end
          end
        end
        SEQ_FIN: begin
          done_q   <= 1'b1;
          known_q  <= known_i;
          family_q <= fam_i;
          sect_q   <= geo_i.sects;
          bottom_q <= geo_i.bottom;
          size_q   <= known_i ? (SIZE_W'(1) << (int'(geo_i.size_lg) + LANE_SH)) : '0;
          st_q     <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign req_o         = (st_q == SEQ_ISSUE);
  assign busy_o        = (st_q != SEQ_IDLE);
  assign mfg_o         = mfg_q;
  assign dev_o         = dev_q;
  assign done_o        = done_q;
  assign known_o       = known_q;
  assign family_o      = family_q;
  assign sect_cnt_o    = sect_q;
  assign size_o        = size_q;
  assign bottom_boot_o = bottom_q;

endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
  import nor_probe_pkg::*;
#(
  parameter int          ADDR_W     = 22,
  parameter int          BUS_W      = 32,
  parameter int          SIZE_W     = 32,
  parameter int          STROBE_CYC = 3,
  parameter logic [7:0]  MFG_UNLOCK = 8'h01,
  parameter logic [7:0]  MFG_STATUS = 8'h89,
  parameter logic [15:0] DEV_UNI64  = 16'h22D7,
  parameter logic [15:0] DEV_BOT8   = 16'h88C1,
  parameter logic [15:0] DEV_BOT16  = 16'h88C3,
  parameter logic [15:0] DEV_BOT32  = 16'h88C5,
  parameter logic [15:0] DEV_BOT64  = 16'h88CD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              known_o,
  output logic [1:0]        family_o,
  output logic [7:0]        sect_cnt_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              bottom_boot_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BUS_W-1:0]  bus_wdata_o,
  input  logic [BUS_W-1:0]  bus_rdata_i,
  output logic              bus_wr_o,
  output logic              bus_rd_o
);

  logic              req;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [BUS_W-1:0]  req_data;
  logic              ack;
  logic [BUS_W-1:0]  rdata;
  logic [7:0]        mfg;
  logic [BUS_W-1:0]  dev;
  fam_e              fam;
  logic              known;
  geo_t              geo;

  nor_bus_cycle #(
    .ADDR_W    (ADDR_W),
    .BUS_W     (BUS_W),
    .STROBE_CYC(STROBE_CYC)
  ) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .we_i       (req_we),
    .addr_i     (req_addr),
    .data_i     (req_data),
    .ack_o      (ack),
    .rdata_o    (rdata),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i),
    .bus_wr_o   (bus_wr_o),
    .bus_rd_o   (bus_rd_o)
  );

  nor_probe_seq #(
    .ADDR_W(ADDR_W),
    .BUS_W (BUS_W),
    .SIZE_W(SIZE_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .req_o        (req),
    .we_o         (req_we),
    .addr_o       (req_addr),
    .data_o       (req_data),
    .ack_i        (ack),
    .rdata_i      (rdata),
    .mfg_o        (mfg),
    .dev_o        (dev),
    .fam_i        (fam),
    .known_i      (known),
    .geo_i        (geo),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .known_o      (known_o),
    .family_o     (family_o),
    .sect_cnt_o   (sect_cnt_o),
    .size_o       (size_o),
    .bottom_boot_o(bottom_boot_o)
  );

  nor_id_decode #(
    .BUS_W     (BUS_W),
    .MFG_UNLOCK(MFG_UNLOCK),
    .MFG_STATUS(MFG_STATUS),
    .DEV_UNI64 (DEV_UNI64),
    .DEV_BOT8  (DEV_BOT8),
    .DEV_BOT16 (DEV_BOT16),
    .DEV_BOT32 (DEV_BOT32),
    .DEV_BOT64 (DEV_BOT64)
  ) u_dec (
    .mfg_i  (mfg),
    .dev_i  (dev),
    .fam_o  (fam),
    .known_o(known),
    .geo_o  (geo)
  );

endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
  parameter int ADDR_W     = 22,
  parameter int BUS_W      = 32,
  parameter int SIZE_W     = 32,
  parameter int STROBE_CYC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              known_o,
  input logic [7:0]        sect_cnt_o,
  input logic [SIZE_W-1:0] size_o,
  input logic              bottom_boot_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [BUS_W-1:0]  bus_wdata_o,
  input logic              bus_wr_o,
  input logic              bus_rd_o
);

  logic [15:0] wr_run_q;
  logic [15:0] rd_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_run_q <= '0;
      rd_run_q <= '0;
    end else begin
      wr_run_q <= bus_wr_o ? wr_run_q + 16'd1 : 16'd0;
      rd_run_q <= bus_rd_o ? rd_run_q + 16'd1 : 16'd0;
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));

  a_r2_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_wr_o) || $rose(bus_rd_o)) |-> ($stable(bus_addr_o) && $stable(bus_wdata_o)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_wr_o) || $fell(bus_rd_o)) |-> ($stable(bus_addr_o) && $stable(bus_wdata_o)));

  a_r2_wr_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_wr_o) |-> (wr_run_q == 16'(STROBE_CYC)));

  a_r3_rd_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_rd_o) |-> (rd_run_q == 16'(STROBE_CYC)));

  a_r5_unknown_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !known_o) |-> (sect_cnt_o == 8'd0 && size_o == '0 && !bottom_boot_o));

  a_r6_known_geo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && known_o) |-> (sect_cnt_o != 8'd0 && size_o != '0));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_wr_o && !bus_rd_o));

endmodule

bind nor_id_probe nor_id_probe_chk #(
  .ADDR_W    (ADDR_W),
  .BUS_W     (BUS_W),
  .SIZE_W    (SIZE_W),
  .STROBE_CYC(STROBE_CYC)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .known_o      (known_o),
  .sect_cnt_o   (sect_cnt_o),
  .size_o       (size_o),
  .bottom_boot_o(bottom_boot_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_wr_o     (bus_wr_o),
  .bus_rd_o     (bus_rd_o)
);

// File: tb/test_nor_id_probe.sv
`timescale 1ns/1ps
module test_nor_id_probe;

  localparam int N_STB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_drv = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] fl_w0 = '0;
  logic [31:0] fl_w1 = '0;

  logic        busy, done, known, bot, wr, rd;
  logic [1:0]  fam;
  logic [7:0]  sect;
  logic [31:0] size;
  logic [21:0] addr;
  logic [31:0] wdata, rdata;

  logic        busy16, done16, known16, bot16, wr16, rd16;
  logic [1:0]  fam16;
  logic [7:0]  sect16;
  logic [31:0] size16;
  logic [21:0] addr16;
  logic [15:0] wdata16, rdata16;

  assign rdata   = !rd   ? 32'h0 : (addr == 22'd0)   ? fl_w0 : (addr == 22'd1)   ? fl_w1 : 32'h0;
  assign rdata16 = !rd16 ? 16'h0 : (addr16 == 22'd0) ? fl_w0[15:0] : (addr16 == 22'd1) ? fl_w1[15:0] : 16'h0;

  nor_id_probe #(.BUS_W(32), .STROBE_CYC(N_STB)) i_nor_id_probe (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_drv),
    .busy_o(busy), .done_o(done), .known_o(known), .family_o(fam),
    .sect_cnt_o(sect), .size_o(size), .bottom_boot_o(bot),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata),
    .bus_wr_o(wr), .bus_rd_o(rd)
  );

  nor_id_probe #(.BUS_W(16), .STROBE_CYC(N_STB)) i_nor_id_probe_w16 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_drv),
    .busy_o(busy16), .done_o(done16), .known_o(known16), .family_o(fam16),
    .sect_cnt_o(sect16), .size_o(size16), .bottom_boot_o(bot16),
    .bus_addr_o(addr16), .bus_wdata_o(wdata16), .bus_rdata_i(rdata16),
    .bus_wr_o(wr16), .bus_rd_o(rd16)
  );

  int n_chk = 0;
  int n_err = 0;
  int done_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference decode, written from the requirements
  task automatic ref_decode(input logic [31:0] w0, input logic [31:0] w1, input int lanes,
                            output logic k, output logic [1:0] f, output logic [7:0] s,
                            output logic [31:0] sz, output logic b);
    int mib;
    bit hit;
    f = (w0[7:0] == 8'h01) ? 2'd1 : (w0[7:0] == 8'h89) ? 2'd2 : 2'd0;
    hit = 1; s = 0; b = 1; mib = 0;
    case (w1[15:0])
      16'h22D7: begin s = 128; mib = 8; b = 0; end
      16'h88C1: begin s = 23;  mib = 1; end
      16'h88C3: begin s = 39;  mib = 2; end
      16'h88C5: begin s = 71;  mib = 4; end
      16'h88CD: begin s = 135; mib = 8; end
      default:  hit = 0;
    endcase
    if (lanes == 2 && w1[31:16] != w1[15:0]) hit = 0;
    k = (f != 2'd0) && hit;
    if (!k) begin s = 0; sz = 0; b = 0; end
    else sz = 32'(mib) * 32'h100000 * 32'(lanes);
  endtask

  function automatic logic [31:0] rep(input logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction

  // cycle-by-cycle expectation
  logic        exp_wr = 0, exp_rd = 0, exp_av = 0, exp_we = 0, exp_busy = 0, exp_done = 0, res_valid = 0;
  logic [21:0] exp_addr = '0;
  logic [31:0] exp_data = '0;
  string       exp_tag = "R1";
  logic        e_known = 0, e_bot = 0, e16_known = 0, e16_bot = 0;
  logic [1:0]  e_fam = 0, e16_fam = 0;
  logic [7:0]  e_sect = 0, e16_sect = 0;
  logic [31:0] e_size = 0, e16_size = 0;

  task automatic run_model();
    logic        t_we   [6];
    logic [21:0] t_ad   [6];
    logic [31:0] t_dt   [6];
    string       t_tg   [6];
    int          n;
    logic [7:0]  mb;
    t_we[0] = 1; t_ad[0] = 22'h555; t_dt[0] = rep(8'hAA); t_tg[0] = "R1";
    t_we[1] = 1; t_ad[1] = 22'h2AA; t_dt[1] = rep(8'h55); t_tg[1] = "R1";
    t_we[2] = 1; t_ad[2] = 22'h555; t_dt[2] = rep(8'h90); t_tg[2] = "R1";
    t_we[3] = 0; t_ad[3] = 22'h000; t_dt[3] = 0;          t_tg[3] = "R3";
    t_we[4] = 0; t_ad[4] = 22'h001; t_dt[4] = 0;          t_tg[4] = "R3";
    mb = fl_w0[7:0];
    n = 5;
    if (mb == 8'h01 || mb == 8'h89) begin
      t_we[5] = 1; t_ad[5] = 22'h000; t_dt[5] = rep(mb == 8'h89 ? 8'hFF : 8'hF0); t_tg[5] = "R8";
      n = 6;
    end
    exp_busy = 1;
    for (int i = 0; i < n; i++) begin
      exp_av = 0; exp_wr = 0; exp_rd = 0;
      @(posedge clk);
      exp_av = 1; exp_addr = t_ad[i]; exp_data = t_dt[i]; exp_we = t_we[i]; exp_tag = t_tg[i];
      for (int c = 0; c < N_STB; c++) begin
        @(posedge clk);
        exp_wr = t_we[i]; exp_rd = !t_we[i];
      end
      @(posedge clk);
      exp_wr = 0; exp_rd = 0;
      @(posedge clk);
      exp_av = 0;
    end
    @(posedge clk);
    exp_busy = 0;
    exp_done = 1;
    res_valid = 1;
    ref_decode(fl_w0, fl_w1, 2, e_known, e_fam, e_sect, e_size, e_bot);
    ref_decode(fl_w0, {16'h0, fl_w1[15:0]}, 1, e16_known, e16_fam, e16_sect, e16_size, e16_bot);
  endtask

  always begin
    @(posedge clk);
    exp_done = 0;
    if (rst_n && start_drv) run_model();
  end

  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) done_cnt++;
      chk(wr === exp_wr, "R2 write strobe", 64'(wr), 64'(exp_wr));
      chk(rd === exp_rd, "R3 read strobe", 64'(rd), 64'(exp_rd));
      chk(busy === exp_busy, "R9 busy", 64'(busy), 64'(exp_busy));
      chk(done === exp_done, "R9 done", 64'(done), 64'(exp_done));
      if (exp_av) begin
        chk(addr === exp_addr, {exp_tag, " address"}, 64'(addr), 64'(exp_addr));
        if (exp_we) chk(wdata === exp_data, {exp_tag, " write data"}, 64'(wdata), 64'(exp_data));
      end
      if (res_valid) begin
        chk(fam === e_fam, "R4 family", 64'(fam), 64'(e_fam));
        chk(known === e_known, "R5 known", 64'(known), 64'(e_known));
        chk(sect === e_sect, "R6 sectors", 64'(sect), 64'(e_sect));
        chk(bot === e_bot, "R6 bottom boot", 64'(bot), 64'(e_bot));
        chk(size === e_size, "R6 size", 64'(size), 64'(e_size));
      end
      if (exp_done) begin
        chk(done16 === 1'b1, "R9 done on 16-bit bus", 64'(done16), 64'd1);
        chk(fam16 === e16_fam, "R4 family 16-bit", 64'(fam16), 64'(e16_fam));
        chk(known16 === e16_known, "R5 known 16-bit", 64'(known16), 64'(e16_known));
        chk(sect16 === e16_sect, "R6 sectors 16-bit", 64'(sect16), 64'(e16_sect));
        chk(size16 === e16_size, "R7 size 16-bit", 64'(size16), 64'(e16_size));
        if (known && known16)
          chk(size === 2 * size16, "R7 size doubles on 32-bit", 64'(size), 64'(2 * size16));
      end
    end
  end

  task automatic run_case(input logic [31:0] w0, input logic [31:0] w1, input bit restart);
    int d0;
    @(negedge clk);
    fl_w0 = w0; fl_w1 = w1;
    start_drv = 1;
    @(negedge clk);
    start_drv = 0;
    d0 = done_cnt;
    if (restart) begin
      repeat (5) @(negedge clk);
      start_drv = 1;
      @(negedge clk);
      start_drv = 0;
      repeat (4 * (N_STB + 3)) @(negedge clk);
      start_drv = 1;
      @(negedge clk);
      start_drv = 0;
    end
    while (!exp_done) @(negedge clk);
    repeat (3) @(negedge clk);
    if (restart) chk(done_cnt - d0 == 1, "R10 single done despite restart", 64'(done_cnt - d0), 64'd1);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done === 0, "R9 reset busy/done", 64'({busy, done}), 64'd0);
    chk(wr === 0 && rd === 0, "R9 reset strobes", 64'({wr, rd}), 64'd0);
    chk(known === 0 && sect === 0 && size === 0 && fam === 0, "R9 reset results",
        64'({known, fam, sect}), 64'd0);
    // status family, 16 Mbit, junk above the low byte of the maker word
    run_case(32'h5A5A_0089, {16'h88C3, 16'h88C3}, 0);
    // unlock family, uniform 64 Mbit, junk in bits [15:8]
    run_case(32'h1234_7701, {16'h22D7, 16'h22D7}, 0);
    run_case(32'h0000_0089, {16'h88C1, 16'h88C1}, 0);
    run_case(32'h0000_0089, {16'h88C5, 16'h88C5}, 0);
    run_case(32'h0000_0089, {16'h88CD, 16'h88CD}, 0);
    // unknown maker: no restore write
    run_case(32'h0000_00C2, {16'h88C1, 16'h88C1}, 0);
    // known maker, lanes disagree: unknown on 32-bit, known on 16-bit, restore still written
    run_case(32'h0000_0089, {16'h0000, 16'h88C1}, 0);
    // known maker, unknown device on unlock family
    run_case(32'h0000_0001, {16'h1111, 16'h1111}, 0);
    // R10: extra start pulses during the run
    run_case(32'h0000_0001, {16'h22D7, 16'h22D7}, 1);
    finish_run();
  end

endmodule